// File: doc/BRIEF.md
# Neighbourhood Window Pixel Addresser

This block turns a base pixel and a small neighbour number into a physical address in a square single-plane pixel store, and holds that store. Software-facing logic elsewhere loads a column register, a row register and a 5-bit neighbour number. Per-axis offset maps then form the physical column and row of one of 25 pixels in the 5x5 window centred on the base. The neighbour number is laid out as a spiral: the centre first, then the ring at distance one, then the ring at distance two. A separate signed offset is not used.

The addressed pixel is returned combinationally, so it can be used in the cycle after the registers are loaded. A write-back to that same pixel can be issued in that cycle. Because a new neighbour number can be loaded in the cycle in which the previous pixel is consumed or written, one pixel access is sustained per clock. A raster scan controller steps the base across the whole plane and raises an end-of-image flag once the last pixel has been stepped past.

The plane side is 2^COORD_W pixels. A 128x128 plane uses COORD_W = 7; the default configuration is 32x32. Coordinates that leave the plane wrap modulo the side.

Top module: `win_pixel_addresser`

## Requirements
- R1: After reset, the base column, base row and neighbour number are 0, so `col_addr` and `row_addr` read 0, and `scan_done` is 0.
- R2: A pulse on `ld_x`, `ld_y` or `ld_idx` loads `x_in`, `y_in` or `idx_in` at that clock edge. The new address appears on `col_addr`/`row_addr` right after that edge.
- R3: Neighbour numbers 0 to 8 select the centre and then the eight adjacent pixels. With the row index growing downward, the (dx,dy) offsets are: 0=(0,0), 1=(+1,0), 2=(+1,-1), 3=(0,-1), 4=(-1,-1), 5=(-1,0), 6=(-1,+1), 7=(0,+1), 8=(+1,+1).
- R4: Neighbour numbers 9 to 24 walk the outer ring counter-clockwise. The offsets are: 9=(+2,+1), 10=(+2,0), 11=(+2,-1), 12=(+2,-2), 13=(+1,-2), 14=(0,-2), 15=(-1,-2), 16=(-2,-2), 17=(-2,-1), 18=(-2,0), 19=(-2,+1), 20=(-2,+2), 21=(-1,+2), 22=(0,+2), 23=(+1,+2), 24=(+2,+2).
- R5: Neighbour numbers 25 to 31 select the base pixel itself.
- R6: A neighbour coordinate outside the plane wraps modulo the plane side on each axis independently.
- R7: `rd_data` always shows the stored pixel at (`col_addr`, `row_addr`). It is therefore valid in the cycle after a register load.
- R8: With `wr_en` high at a clock edge, `wr_data` is stored at the current address. A read of that address in the next cycle returns the new value.
- R9: A write and a neighbour-number load in the same cycle write the old address. The pixel at the new address is then read in the next cycle, unaltered.
- R10: `scan_start` sets both base coordinates to 0 and clears `scan_done`. It takes priority over `ld_x`, `ld_y` and `scan_step`.
- R11: While a scan runs, each `scan_step` adds one to the column. Stepping from the last column goes to column 0 of the next row.
- R12: The step from the last pixel (both coordinates at their maximum) wraps the base to (0,0). `scan_done` rises one cycle later and holds until the next `scan_start`.
- R13: `scan_step` has no effect before the first `scan_start` and once `scan_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_x | input | 1 | Load base column |
| x_in | input | COORD_W | Base column value |
| ld_y | input | 1 | Load base row |
| y_in | input | COORD_W | Base row value |
| ld_idx | input | 1 | Load neighbour number |
| idx_in | input | 5 | Neighbour number, 0 to 24 |
| scan_start | input | 1 | Start a raster scan from (0,0) |
| scan_step | input | 1 | Advance the scan by one pixel |
| wr_en | input | 1 | Write the addressed pixel |
| wr_data | input | PIX_W | Pixel value to write |
| col_addr | output | COORD_W | Physical column of the addressed pixel |
| row_addr | output | COORD_W | Physical row of the addressed pixel |
| rd_data | output | PIX_W | Addressed pixel value |
| scan_done | output | 1 | End of image reached |

## Verification
The checker watches the scan controller on every cycle. It confirms that a start zeroes the base, that each step advances the column or moves to the next row, that the done flag follows the final step and then holds, and that steps are ignored once the flag is high. It also confirms that the centre and out-of-range neighbour numbers address the base pixel. The full spiral offset map, the modulo wrap at every edge, and the read-after-write and pipelined write-then-move orderings depend on stored pixel contents. These are shown only by the bench, which fills the plane and then sweeps every base with every neighbour number.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;

  localparam int NB_IDX_W = 5;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_RUN  = 2'd1,
    SC_LAST = 2'd2,
    SC_DONE = 2'd3
  } scan_state_e;

  typedef struct packed {
    logic signed [2:0] dx;
    logic signed [2:0] dy;
  } nb_offset_t;

  function automatic nb_offset_t mk_off(input int dx, input int dy);
    nb_offset_t r;
    r.dx = 3'(dx);
    r.dy = 3'(dy);
    return r;
  endfunction

  // Spiral layout: centre, inner ring from east counter-clockwise,
  // outer ring starting just below east, counter-clockwise.
  function automatic nb_offset_t nb_offset(input logic [NB_IDX_W-1:0] idx);
    nb_offset_t r;
    case (idx)
      5'd1:    r = mk_off( 1,  0);
      5'd2:    r = mk_off( 1, -1);
      5'd3:    r = mk_off( 0, -1);
      5'd4:    r = mk_off(-1, -1);
      5'd5:    r = mk_off(-1,  0);
      5'd6:    r = mk_off(-1,  1);
      5'd7:    r = mk_off( 0,  1);
      5'd8:    r = mk_off( 1,  1);
      5'd9:    r = mk_off( 2,  1);
      5'd10:   r = mk_off( 2,  0);
      5'd11:   r = mk_off( 2, -1);
      5'd12:   r = mk_off( 2, -2);
      5'd13:   r = mk_off( 1, -2);
      5'd14:   r = mk_off( 0, -2);
      5'd15:   r = mk_off(-1, -2);
      5'd16:   r = mk_off(-2, -2);
      5'd17:   r = mk_off(-2, -1);
      5'd18:   r = mk_off(-2,  0);
      5'd19:   r = mk_off(-2,  1);
      5'd20:   r = mk_off(-2,  2);
      5'd21:   r = mk_off(-1,  2);
      5'd22:   r = mk_off( 0,  2);
      5'd23:   r = mk_off( 1,  2);
      5'd24:   r = mk_off( 2,  2);
      default: r = mk_off( 0,  0);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/win_axis_map.sv
module win_axis_map
  import win_addr_pkg::*;
#(
  parameter int COORD_W = 5,
  parameter int AXIS    = 0
) (
  input  logic [COORD_W-1:0]  coord,
  input  logic [NB_IDX_W-1:0] idx,
  output logic [COORD_W-1:0]  phys
);

  nb_offset_t        off;
  logic signed [2:0] delta;
  logic [COORD_W-1:0] delta_ext;

  always_comb begin
    off = nb_offset(idx);
    if (AXIS == 0) delta = off.dx;
    else           delta = off.dy;
    delta_ext = {{(COORD_W-3){delta[2]}}, delta};
    // Truncating sum gives modulo-side wrap.
    phys = coord + delta_ext;
  end

endmodule

// File: rtl/win_scan_ctrl.sv
module win_scan_ctrl
  import win_addr_pkg::*;
#(
  parameter int COORD_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_start,
  input  logic               scan_step,
  input  logic               ld_x,
  input  logic [COORD_W-1:0] x_in,
  input  logic               ld_y,
  input  logic [COORD_W-1:0] y_in,
  output logic [COORD_W-1:0] x_q,
  output logic [COORD_W-1:0] y_q,
  output scan_state_e        st_q,
  output logic               scan_done
);

  localparam logic [COORD_W-1:0] CMAX = '1;

  logic [COORD_W-1:0] x_d, y_d;
  logic               x_en, y_en, st_en;
  scan_state_e        st_d;
  logic               step_go;

  assign step_go = (st_q == SC_RUN) && scan_step && !scan_start;

  always_comb begin
    x_d   = x_q;
    y_d   = y_q;
    x_en  = 1'b0;
    y_en  = 1'b0;
    st_d  = st_q;
    st_en = 1'b0;
    if (scan_start) begin
      x_d   = '0;
      y_d   = '0;
      x_en  = 1'b1;
      y_en  = 1'b1;
      st_d  = SC_RUN;
      st_en = 1'b1;
    end else if (step_go) begin
      x_d  = x_q + 1'b1;
      x_en = 1'b1;
      if (x_q == CMAX) begin
        y_d  = y_q + 1'b1;
        y_en = 1'b1;
        if (y_q == CMAX) begin
          st_d  = SC_LAST;
          st_en = 1'b1;
        end
      end
    end else begin
      if (ld_x) begin
        x_d  = x_in;
        x_en = 1'b1;
      end
      if (ld_y) begin
        y_d  = y_in;
        y_en = 1'b1;
      end
      if (st_q == SC_LAST) begin
        st_d  = SC_DONE;
        st_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
    end else if (x_en) begin
      x_q <= x_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else if (y_en) begin
      y_q <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SC_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign scan_done = (st_q == SC_DONE);

endmodule

// File: rtl/win_pixel_store.sv
module win_pixel_store #(
  parameter int COORD_W = 5,
  parameter int PIX_W   = 8
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic [PIX_W-1:0]   wr_data,
  output logic [PIX_W-1:0]   rd_data
);

  localparam int ADDR_W = 2 * COORD_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [PIX_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  assign addr    = {row, col};
  assign rd_data = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

endmodule

// File: rtl/win_pixel_addresser.sv
module win_pixel_addresser
  import win_addr_pkg::*;
#(
  parameter int COORD_W = 5,
  parameter int PIX_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_x,
  input  logic [COORD_W-1:0]  x_in,
  input  logic                ld_y,
  input  logic [COORD_W-1:0]  y_in,
  input  logic                ld_idx,
  input  logic [NB_IDX_W-1:0] idx_in,
  input  logic                scan_start,
  input  logic                scan_step,
  input  logic                wr_en,
  input  logic [PIX_W-1:0]    wr_data,
  output logic [COORD_W-1:0]  col_addr,
  output logic [COORD_W-1:0]  row_addr,
  output logic [PIX_W-1:0]    rd_data,
  output logic                scan_done
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  logic [COORD_W-1:0]  x_q, y_q;
  logic [NB_IDX_W-1:0] idx_q;
  logic [NB_IDX_W-1:0] idx_d;
  logic                idx_en;
  scan_state_e         st_q;

  always_comb begin
    idx_en = ld_idx;
    idx_d  = idx_in;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  win_scan_ctrl #(.COORD_W(COORD_W)) scan_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scan_start (scan_start),
    .scan_step  (scan_step),
    .ld_x       (ld_x),
    .x_in       (x_in),
    .ld_y       (ld_y),
    .y_in       (y_in),
    .x_q        (x_q),
    .y_q        (y_q),
    .st_q       (st_q),
    .scan_done  (scan_done)
  );

  logic [COORD_W-1:0] axis_base [2];
  logic [COORD_W-1:0] axis_phys [2];

  assign axis_base[0] = x_q;
  assign axis_base[1] = y_q;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    win_axis_map #(.COORD_W(COORD_W), .AXIS(a)) map_i (
      .coord (axis_base[a]),
      .idx   (idx_q),
      .phys  (axis_phys[a])
    );
  end

  assign col_addr = axis_phys[0];
  assign row_addr = axis_phys[1];

  win_pixel_store #(.COORD_W(COORD_W), .PIX_W(PIX_W)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .col     (col_addr),
    .row     (row_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/win_pixel_addresser_chk.sv
module win_pixel_addresser_chk
  import win_addr_pkg::*;
#(
  parameter int COORD_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_start,
  input logic                scan_step,
  input logic                ld_x,
  input logic                ld_y,
  input logic [COORD_W-1:0]  x_q,
  input logic [COORD_W-1:0]  y_q,
  input logic [NB_IDX_W-1:0] idx_q,
  input scan_state_e         st_q,
  input logic [COORD_W-1:0]  col_addr,
  input logic [COORD_W-1:0]  row_addr,
  input logic                scan_done
);

  localparam logic [COORD_W-1:0] CMAX = '1;

  // R10
  a_r10_start_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> (x_q == '0 && y_q == '0 && !scan_done));

  // R11
  a_r11_step_column: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_RUN && scan_step && !scan_start && x_q != CMAX)
    |=> (x_q == $past(x_q) + 1'b1 && y_q == $past(y_q)));

  // R11
  a_r11_step_row: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_RUN && scan_step && !scan_start && x_q == CMAX && y_q != CMAX)
    |=> (x_q == '0 && y_q == $past(y_q) + 1'b1));

  // R12
  a_r12_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_LAST && !scan_start) |=> scan_done);

  // R12
  a_r12_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !scan_start) |=> scan_done);

  // R13
  a_r13_done_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && scan_step && !scan_start && !ld_x && !ld_y)
    |=> ($stable(x_q) && $stable(y_q)));

  // R13
  a_r13_idle_ignores_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_IDLE && scan_step && !scan_start && !ld_x && !ld_y)
    |=> ($stable(x_q) && $stable(y_q)));

  // R3
  a_r3_zero_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0) |-> (col_addr == x_q && row_addr == y_q));

  // R5
  a_r5_high_is_base: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q > 5'd24) |-> (col_addr == x_q && row_addr == y_q));

endmodule

bind win_pixel_addresser win_pixel_addresser_chk #(.COORD_W(COORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .scan_start (scan_start),
  .scan_step  (scan_step),
  .ld_x       (ld_x),
  .ld_y       (ld_y),
  .x_q        (x_q),
  .y_q        (y_q),
  .idx_q      (idx_q),
  .st_q       (st_q),
  .col_addr   (col_addr),
  .row_addr   (row_addr),
  .scan_done  (scan_done)
);

// File: tb/win_pixel_addresser_tb_top.sv
`timescale 1ns/1ps
module win_pixel_addresser_tb_top;

  localparam int CW   = 5;
  localparam int PW   = 8;
  localparam int SIDE = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_x, ld_y, ld_idx;
  logic [CW-1:0] x_in, y_in;
  logic [4:0]    idx_in;
  logic          scan_start, scan_step, wr_en;
  logic [PW-1:0] wr_data;
  logic [CW-1:0] col_addr, row_addr;
  logic [PW-1:0] rd_data;
  logic          scan_done;

  int errors = 0;
  int checks = 0;
  logic [PW-1:0] model [SIDE*SIDE];

  always #2.5 clk = ~clk;

  win_pixel_addresser #(.COORD_W(CW), .PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_x(ld_x), .x_in(x_in), .ld_y(ld_y), .y_in(y_in),
    .ld_idx(ld_idx), .idx_in(idx_in), .scan_start(scan_start), .scan_step(scan_step),
    .wr_en(wr_en), .wr_data(wr_data), .col_addr(col_addr), .row_addr(row_addr),
    .rd_data(rd_data), .scan_done(scan_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic int pat(input int x, input int y);
    return (x * 7 + y * 29 + 3) & 255;
  endfunction

  function automatic int off_dx(input int i);
    case (i)
      1, 2, 8, 13, 23: return 1;
      9, 10, 11, 12, 24: return 2;
      4, 5, 6, 15, 21: return -1;
      16, 17, 18, 19, 20: return -2;
      default: return 0;
    endcase
  endfunction

  function automatic int off_dy(input int i);
    case (i)
      2, 3, 4, 11, 17: return -1;
      12, 13, 14, 15, 16: return -2;
      6, 7, 8, 9, 19: return 1;
      20, 21, 22, 23, 24: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int ex, ey;
    rst_n = 1'b0;
    ld_x = 0; ld_y = 0; ld_idx = 0; x_in = '0; y_in = '0; idx_in = '0;
    scan_start = 0; scan_step = 0; wr_en = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) cyc();

    // R1 reset state
    check(col_addr == 0, "R1 col", int'(col_addr), 0);
    check(row_addr == 0, "R1 row", int'(row_addr), 0);
    check(scan_done == 0, "R1 done", int'(scan_done), 0);

    // R13 step before any start
    scan_step = 1; cyc(); scan_step = 0;
    check(col_addr == 0 && row_addr == 0, "R13 idle step", int'(col_addr), 0);

    // R10/R11 fill plane with a scan, writing each pixel while stepping
    scan_start = 1; cyc(); scan_start = 0;
    check(col_addr == 0 && row_addr == 0, "R10 start", int'(col_addr), 0);
    ex = 0; ey = 0;
    for (int n = 0; n < SIDE * SIDE; n++) begin
      check(col_addr == CW'(ex), "R11 col", int'(col_addr), ex);
      check(row_addr == CW'(ey), "R11 row", int'(row_addr), ey);
      check(scan_done == 0, "R12 early", int'(scan_done), 0);
      wr_en = 1; wr_data = PW'(pat(ex, ey)); scan_step = 1;
      cyc();
      model[ey * SIDE + ex] = PW'(pat(ex, ey));
      ex++;
      if (ex == SIDE) begin ex = 0; ey++; end
    end
    wr_en = 0; scan_step = 0;
    // R12 base wrapped, flag not yet up
    check(col_addr == 0 && row_addr == 0, "R12 wrap", int'(row_addr), 0);
    check(scan_done == 0, "R12 one-cycle lag", int'(scan_done), 0);
    cyc();
    check(scan_done == 1, "R12 done", int'(scan_done), 1);
    // R13 steps ignored once done
    scan_step = 1; cyc(); cyc(); scan_step = 0;
    check(col_addr == 0 && row_addr == 0, "R13 done step", int'(col_addr), 0);
    check(scan_done == 1, "R12 hold", int'(scan_done), 1);

    // R2..R7 sweep every base with every neighbour number
    for (int y = 0; y < SIDE; y++) begin
      for (int x = 0; x < SIDE; x++) begin
        for (int i = 0; i < 32; i++) begin
          int cx, cy;
          string tag;
          ld_x = 1; ld_y = 1; ld_idx = 1;
          x_in = CW'(x); y_in = CW'(y); idx_in = 5'(i);
          cyc();
          cx = (x + off_dx(i)) & (SIDE - 1);
          cy = (y + off_dy(i)) & (SIDE - 1);
          if (i > 24) tag = "R5";
          else if (x + off_dx(i) != cx || y + off_dy(i) != cy) tag = "R6";
          else if (i > 8) tag = "R4";
          else tag = "R3";
          if (x == 0 && y == 0 && i == 0) tag = "R2";
          check(col_addr == CW'(cx), {tag, " col"}, int'(col_addr), cx);
          check(row_addr == CW'(cy), {tag, " row"}, int'(row_addr), cy);
          check(rd_data == model[cy * SIDE + cx], "R7 data",
                int'(rd_data), int'(model[cy * SIDE + cx]));
        end
      end
    end
    ld_x = 0; ld_y = 0; ld_idx = 0;

    // R9 write and move in the same cycle
    ld_x = 1; ld_y = 1; ld_idx = 1; x_in = 3; y_in = 4; idx_in = 1;
    cyc();
    ld_x = 0; ld_y = 0;
    wr_en = 1; wr_data = 8'hA5; idx_in = 7;
    cyc();
    model[4 * SIDE + 4] = 8'hA5;
    wr_en = 0;
    check(rd_data == model[5 * SIDE + 3], "R9 new pixel", int'(rd_data),
          int'(model[5 * SIDE + 3]));
    idx_in = 1;
    cyc();
    ld_idx = 0;
    check(rd_data == 8'hA5, "R8 read after write", int'(rd_data), 8'hA5);
    // R8 write then read the same address next cycle
    wr_en = 1; wr_data = 8'h3C;
    cyc();
    wr_en = 0;
    check(rd_data == 8'h3C, "R8 same address", int'(rd_data), 8'h3C);

    // R10 start overrides loads and clears done
    scan_start = 1; ld_x = 1; ld_y = 1; x_in = 9; y_in = 9; ld_idx = 1; idx_in = 0;
    cyc();
    scan_start = 0; ld_x = 0; ld_y = 0; ld_idx = 0;
    check(col_addr == 0 && row_addr == 0, "R10 priority", int'(col_addr), 0);
    check(scan_done == 0, "R10 clear", int'(scan_done), 0);
    scan_step = 1; cyc(); cyc(); cyc(); scan_step = 0;
    check(col_addr == 3 && row_addr == 0, "R11 restart steps", int'(col_addr), 3);
    // R2 load during a running scan without a step
    ld_y = 1; y_in = 17; cyc(); ld_y = 0;
    check(row_addr == 17 && col_addr == 3, "R2 load in scan", int'(row_addr), 17);

    report();
  end

endmodule